// File: doc/BRIEF.md
# Synchronous Serial CRC Generator and Checker

This block keeps a 16-bit cyclic redundancy check over a bit-serial synchronous link. It has two sides. The transmit generator folds outgoing data bits into its register and then shifts the result out on request, most significant bit first. The receive checker folds incoming bits and flags a frame as good when its remainder is zero. Both sides follow the same two configuration inputs. One picks the polynomial and the other picks an all-ones or all-zeros starting value.

The receive side is driven by framing logic outside the block. That logic marks the last bit of each character and says whether the character is a sync pattern. Each character is first accumulated into a one-character speculative register. At the character boundary it is either committed to the visible checker register or dropped. This lets the checker leave stripped sync characters out of the calculation. It also lets the first data character still count in full when accumulation only starts once that character has been delivered. While the receiver hunts, or on a reset-checker pulse, the checker is held at its starting value.

Top module: `crc_sync_engine`

## Requirements
- R1: With `cfg_crc16_i`=1 both sides use the polynomial 0x8005 (x^16+x^15+x^2+1); with 0 they use 0x1021 (x^16+x^12+x^5+1). The register is not reflected. Each valid bit is processed in one step: feedback = reg[15] xor bit, then reg = (reg<<1) xor (feedback ? poly : 0).
- R2: `cfg_preset_ones_i`=1 makes the starting value 0xFFFF and 0 makes it 0x0000, for both sides. An asynchronous reset clears both registers to 0x0000.
- R3: A `tx_rst_i` pulse loads the generator with the starting value one cycle later. It takes priority over shifting and data bits.
- R4: While `tx_shift_i` is high, `tx_ser_o` shows generator bit 15. Each such cycle the register shifts left by one with a zero entering bit 0, so 16 shifts send the CRC MSB first and leave 0x0000.
- R5: While `hunt_i` is high the checker is loaded with the starting value every cycle, and the record of a delivered data character is cleared.
- R6: A `chk_rst_i` pulse loads the checker with the starting value and clears the delivered-data record.
- R7: A character that ends while `chk_en_i`=0 is not included: `rx_crc_o` is unchanged after it.
- R8: With `strip_en_i`=1, a character flagged by `rx_char_sync_i` is never included.
- R9: With `strip_en_i`=0, sync characters that end before the first included data character are excluded. Sync characters after it are included. All bits of the first data character are included.
- R10: `rx_crc_o` changes only one cycle after a character end, or after a preset. Bits inside a character do not show until that character commits.
- R11: `rx_crc_ok_o` is 1 exactly when `rx_crc_o` is 0x0000. A frame followed by its own CRC, sent MSB first, gives 1; a corrupted CRC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_crc16_i | input | 1 | Polynomial select: 1 = 0x8005, 0 = 0x1021 |
| cfg_preset_ones_i | input | 1 | Starting value: 1 = all ones, 0 = all zeros |
| chk_en_i | input | 1 | Checker accumulation enable |
| strip_en_i | input | 1 | Sync characters are stripped |
| hunt_i | input | 1 | Receiver is hunting for sync |
| chk_rst_i | input | 1 | Reset-checker command pulse |
| rx_bit_i | input | 1 | Received serial bit |
| rx_bit_vld_i | input | 1 | Received bit is valid |
| rx_char_end_i | input | 1 | Current valid bit is the last bit of a character |
| rx_char_sync_i | input | 1 | Character ending now is a sync character |
| tx_rst_i | input | 1 | Load generator with starting value |
| tx_bit_i | input | 1 | Transmit data bit |
| tx_bit_vld_i | input | 1 | Transmit data bit is valid |
| tx_shift_i | input | 1 | Shift generator out one bit |
| tx_crc_o | output | 16 | Generator register |
| tx_ser_o | output | 1 | Generator serial output (bit 15) |
| rx_crc_o | output | 16 | Committed checker register |
| rx_crc_ok_o | output | 1 | Checker remainder is zero |

## Verification
The bench builds the block with its default 16-bit register and uses 8-bit characters. It sweeps all four combinations of polynomial and starting value. At that size a short bit-serial arithmetic model in the bench gives the exact register value after every character. This covers generator output, shift-out order, sync exclusion with and without stripping, the disabled checker, mid-character visibility and a corrupted trailing CRC, each under every configuration.

// File: rtl/crc_sync_pkg.sv
package crc_sync_pkg;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] POLY_CRC16 = 16'h8005;
  localparam logic [CRC_W-1:0] POLY_CCITT = 16'h1021;

  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0] cur, input logic din, input logic sel16);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    crc_step = {cur[CRC_W-2:0], 1'b0} ^ (fb ? (sel16 ? POLY_CRC16 : POLY_CCITT) : '0);
  endfunction
endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr
  import crc_sync_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel16_i,
  input  logic             load_i,
  input  logic [CRC_W-1:0] load_val_i,
  input  logic             shift_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o,
  output logic [CRC_W-1:0] nxt_o
);
  logic [CRC_W-1:0] crc_q;

  assign nxt_o = step_i ? crc_step(crc_q, bit_i, sel16_i) : crc_q;
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (load_i)  crc_q <= load_val_i;
    else if (shift_i) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
    else              crc_q <= nxt_o;
  end
endmodule

// File: rtl/crc_rx_gate.sv
module crc_rx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic char_end_i,
  input  logic char_sync_i,
  input  logic strip_en_i,
  input  logic chk_en_i,
  output logic commit_o
);
  logic started_q;

  // sync chars drop when stripped, or before first data char
  assign commit_o = char_end_i && chk_en_i && !(char_sync_i && (strip_en_i || !started_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       started_q <= 1'b0;
    else if (clear_i)  started_q <= 1'b0;
    else if (commit_o) started_q <= 1'b1;
  end

  a_r9_sync_before_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_end_i && char_sync_i && !started_q) |-> !commit_o);
  a_r8_strip_never_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_end_i && char_sync_i && strip_en_i) |-> !commit_o);
endmodule

// File: rtl/crc_sync_engine.sv
module crc_sync_engine
  import crc_sync_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_crc16_i,
  input  logic             cfg_preset_ones_i,
  input  logic             chk_en_i,
  input  logic             strip_en_i,
  input  logic             hunt_i,
  input  logic             chk_rst_i,
  input  logic             rx_bit_i,
  input  logic             rx_bit_vld_i,
  input  logic             rx_char_end_i,
  input  logic             rx_char_sync_i,
  input  logic             tx_rst_i,
  input  logic             tx_bit_i,
  input  logic             tx_bit_vld_i,
  input  logic             tx_shift_i,
  output logic [CRC_W-1:0] tx_crc_o,
  output logic             tx_ser_o,
  output logic [CRC_W-1:0] rx_crc_o,
  output logic             rx_crc_ok_o
);
  logic [CRC_W-1:0] preset, spec_crc, spec_nxt, com_nxt, spec_load_val, tx_nxt;
  logic             rx_clear, commit;

  assign preset   = {CRC_W{cfg_preset_ones_i}};
  assign rx_clear = hunt_i || chk_rst_i;

  crc_lfsr u_tx (
    .clk_i, .rst_ni, .sel16_i(cfg_crc16_i),
    .load_i(tx_rst_i), .load_val_i(preset),
    .shift_i(tx_shift_i), .step_i(tx_bit_vld_i), .bit_i(tx_bit_i),
    .crc_o(tx_crc_o), .nxt_o(tx_nxt)
  );
  assign tx_ser_o = tx_crc_o[CRC_W-1];

  crc_rx_gate u_gate (
    .clk_i, .rst_ni, .clear_i(rx_clear),
    .char_end_i(rx_char_end_i && rx_bit_vld_i), .char_sync_i(rx_char_sync_i),
    .strip_en_i, .chk_en_i, .commit_o(commit)
  );

  // speculative register holds the character in flight
  assign spec_load_val = rx_clear ? preset : (commit ? spec_nxt : rx_crc_o);

  crc_lfsr u_spec (
    .clk_i, .rst_ni, .sel16_i(cfg_crc16_i),
    .load_i(rx_clear || (rx_char_end_i && rx_bit_vld_i)), .load_val_i(spec_load_val),
    .shift_i(1'b0), .step_i(rx_bit_vld_i), .bit_i(rx_bit_i),
    .crc_o(spec_crc), .nxt_o(spec_nxt)
  );

  crc_lfsr u_com (
    .clk_i, .rst_ni, .sel16_i(cfg_crc16_i),
    .load_i(rx_clear || commit), .load_val_i(rx_clear ? preset : spec_nxt),
    .shift_i(1'b0), .step_i(1'b0), .bit_i(1'b0),
    .crc_o(rx_crc_o), .nxt_o(com_nxt)
  );

  assign rx_crc_ok_o = (rx_crc_o == '0);

  a_r5_hunt_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_i |=> rx_crc_o == {CRC_W{$past(cfg_preset_ones_i)}});
  a_r6_chk_rst_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_rst_i |=> rx_crc_o == {CRC_W{$past(cfg_preset_ones_i)}});
  a_r3_tx_rst_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_i |=> tx_crc_o == {CRC_W{$past(cfg_preset_ones_i)}});
  a_r7_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_en_i && !rx_clear) |=> $stable(rx_crc_o));
  a_r10_no_mid_char_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_char_end_i && !rx_clear) |=> $stable(rx_crc_o));
  a_r4_shift_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_shift_i && !tx_rst_i) |=> tx_crc_o[0] == 1'b0);
  a_r11_ok_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_crc_ok_o |-> $countones(rx_crc_o) == 0);
endmodule

// File: tb/tb_crc_sync_engine.sv
module tb_crc_sync_engine;
  logic clk = 0, rst_n = 0;
  logic crc16 = 0, ones = 0, chk_en = 1, strip = 0, hunt = 0, chk_rst = 0;
  logic rx_bit = 0, rx_vld = 0, rx_end = 0, rx_sync = 0;
  logic tx_rst = 0, tx_bit = 0, tx_vld = 0, tx_shift = 0;
  logic [15:0] tx_crc, rx_crc;
  logic tx_ser, rx_ok;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crc_sync_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_crc16_i(crc16), .cfg_preset_ones_i(ones),
    .chk_en_i(chk_en), .strip_en_i(strip), .hunt_i(hunt), .chk_rst_i(chk_rst),
    .rx_bit_i(rx_bit), .rx_bit_vld_i(rx_vld), .rx_char_end_i(rx_end),
    .rx_char_sync_i(rx_sync), .tx_rst_i(tx_rst), .tx_bit_i(tx_bit),
    .tx_bit_vld_i(tx_vld), .tx_shift_i(tx_shift), .tx_crc_o(tx_crc),
    .tx_ser_o(tx_ser), .rx_crc_o(rx_crc), .rx_crc_ok_o(rx_ok)
  );

  function automatic logic [15:0] m_byte(logic [15:0] c, logic [7:0] b, logic p16);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ b[i];
      c = {c[14:0], 1'b0} ^ (fb ? (p16 ? 16'h8005 : 16'h1021) : 16'h0);
    end
    return c;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rx_byte(logic [7:0] b, logic s);
    for (int i = 7; i >= 0; i--) begin
      rx_bit = b[i]; rx_vld = 1; rx_end = (i == 0); rx_sync = s;
      @(negedge clk);
    end
    rx_vld = 0; rx_end = 0; rx_sync = 0;
  endtask

  task automatic tx_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tx_bit = b[i]; tx_vld = 1;
      @(negedge clk);
    end
    tx_vld = 0;
  endtask

  task automatic do_hunt();
    hunt = 1; @(negedge clk); @(negedge clk);
    check("R5 hunt preset", rx_crc, {16{ones}});
    hunt = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pre, c, c2;
    logic [7:0] d0, d1;
    @(negedge clk);
    check("R2 reset tx", tx_crc, 16'h0);
    check("R2 reset rx", rx_crc, 16'h0);
    rst_n = 1; @(negedge clk);
    for (int cfg = 0; cfg < 4; cfg++) begin
      crc16 = cfg[1]; ones = cfg[0]; pre = {16{ones}};
      d0 = 8'hA5 ^ 8'(cfg); d1 = 8'h3C + 8'(cfg * 17);
      // transmit
      tx_rst = 1; @(negedge clk); tx_rst = 0;
      check("R3 tx preset", tx_crc, pre);
      tx_byte(d0); tx_byte(d1); tx_byte(8'h5E);
      c = m_byte(m_byte(m_byte(pre, d0, crc16), d1, crc16), 8'h5E, crc16);
      check("R1 tx crc", tx_crc, c);
      for (int i = 15; i >= 0; i--) begin
        check("R4 tx serial", {15'h0, tx_ser}, {15'h0, c[i]});
        tx_shift = 1; @(negedge clk);
      end
      tx_shift = 0;
      check("R4 tx drained", tx_crc, 16'h0);
      // receive, no stripping
      strip = 0; do_hunt();
      rx_byte(8'h16, 1); rx_byte(8'h16, 1);
      check("R9 leading sync excluded", rx_crc, pre);
      rx_bit = 1; rx_vld = 1;
      for (int i = 0; i < 4; i++) @(negedge clk);
      rx_vld = 0;
      check("R10 partial char hidden", rx_crc, pre);
      chk_rst = 1; @(negedge clk); chk_rst = 0;
      check("R6 chk reset preset", rx_crc, pre);
      rx_byte(d0, 0);
      c = m_byte(pre, d0, crc16);
      check("R9 first data included", rx_crc, c);
      rx_byte(8'h16, 1);
      c = m_byte(c, 8'h16, crc16);
      check("R9 later sync included", rx_crc, c);
      chk_en = 0; rx_byte(8'hC3, 0);
      check("R7 disabled ignored", rx_crc, c);
      chk_en = 1;
      rx_byte(d1, 0);
      c = m_byte(c, d1, crc16);
      check("R1 rx crc", rx_crc, c);
      rx_byte(c[15:8], 0); rx_byte(c[7:0], 0);
      check("R11 good remainder", rx_crc, 16'h0);
      check("R11 ok flag", {15'h0, rx_ok}, 16'h1);
      // receive, stripping
      strip = 1; do_hunt();
      rx_byte(8'h16, 1); rx_byte(d0, 0); rx_byte(8'h16, 1); rx_byte(d1, 0);
      c = m_byte(m_byte(pre, d0, crc16), d1, crc16);
      check("R8 stripped sync excluded", rx_crc, c);
      c2 = c ^ 16'h0001;
      rx_byte(c2[15:8], 0); rx_byte(c2[7:0], 0);
      check("R11 bad flag", {15'h0, rx_ok}, 16'h0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule